// File: doc/BRIEF.md
# BCD time-of-day calendar counter

This block keeps wall-clock time and a calendar as seven packed BCD bytes: seconds, minutes, hours, day of week, date, month and a two-digit year meaning 2000 to 2099. A fast fractional strobe drives an internal prescaler. Every `PRESCALE_DIV` strobes the prescaler produces one second step, and that step ripples through the carry chain from seconds up to the year. The hour byte selects its own format. When bit 6 is set the hour runs as 1 to 12 with a PM flag in bit 5. When bit 6 is clear it runs as 00 to 23.

Software loads any byte through a simple write port. Addresses 0 to 6 select seconds, minutes, hours, day of week, date, month and year. Address 7 is the control byte, and only its bit 7 (oscillator off, active high) has any effect. All seven time bytes are visible at the outputs at all times. A one-cycle `sec_tick` pulse marks every counted change of the seconds. Alarm comparators placed beside the block can use it.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset the seconds, minutes and hour read 00 (24-hour midnight), day of week reads 1, date 01, month 01, year 00, `sec_tick` is low, and the oscillator is stopped (control bit 7 set).
- R2: While control bit 7 is set, `frac_tick` has no effect and no time byte changes except by a write. Writing control with bit 7 clear starts counting, whatever the other control bits hold.
- R3: While running, seconds advance once per `PRESCALE_DIV` cycles with `frac_tick` high. `sec_tick` is high for exactly the one cycle in which the new seconds value first appears.
- R4: Seconds and minutes count BCD 00 to 59. 59 wraps to 00 and carries into the next field.
- R5: In 24-hour mode (hour bit 6 clear) the hour counts BCD 00 to 23. 23:59:59 wraps to 00:00:00 and advances the date.
- R6: In 12-hour mode (bit 6 set, bit 5 = PM, bits 4:0 = BCD 1 to 12), 11:59:59 advances to 12:00:00 with PM toggled, and 12:59:59 advances to 01:00:00 with PM unchanged. 11:59:59 PM becomes 12:00:00 AM and advances the date. Bit 6 stays set.
- R7: On each date advance the day of week steps by one, and 7 wraps to 1.
- R8: The date wraps to 01 after the last day of the month: 31 for months 01, 03, 05, 07, 08, 10 and 12; 30 for 04, 06, 09 and 11; for 02, 29 when the year is divisible by 4 and 28 otherwise.
- R9: Month 12 wraps to 01 and increments the year. Year 99 wraps to 00.
- R10: A write with address 0 to 6 loads the byte into that field, which shows it the next cycle. The write wins over a count update of the same field in that cycle, while the other fields update normally.
- R11: A write to the seconds (address 0) clears the prescaler and suppresses any step in that cycle. The next second then needs a full `PRESCALE_DIV` running strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frac_tick | input | 1 | Sub-second strobe into the prescaler |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 3 | Write address: 0 sec, 1 min, 2 hour, 3 day of week, 4 date, 5 month, 6 year, 7 control |
| wr_data | input | 8 | Write byte |
| sec_o | output | 8 | Seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | Hour byte with mode and PM flags |
| wday_o | output | 8 | Day of week, 1 to 7 |
| date_o | output | 8 | Day of month, BCD |
| month_o | output | 8 | Month, BCD |
| year_o | output | 8 | Year within the century, BCD |
| sec_tick | output | 1 | One-cycle pulse on each counted seconds change |

## Verification
A wrong prescaler phase shows up as a seconds change that is one or more strobes early or late. `sec_tick` exposes it in the very cycle it happens. A broken carry or month-length decode stays hidden until a rollover. For that reason the bench loads times one or two seconds before each boundary: midnight, noon, 12-to-1, month ends, leap February and year end. A behavioural reference then compares all seven bytes and the tick on every clock, so any corrupted field is visible in the cycle right after the edge that wrote it.

// File: rtl/cal_pkg.sv
package cal_pkg;

    typedef enum logic [2:0] {
        A_SEC   = 3'd0,
        A_MIN   = 3'd1,
        A_HOUR  = 3'd2,
        A_WDAY  = 3'd3,
        A_DATE  = 3'd4,
        A_MONTH = 3'd5,
        A_YEAR  = 3'd6,
        A_CTRL  = 3'd7
    } reg_addr_e;

    typedef struct packed {
        logic       carry;
        logic [7:0] val;
    } step_t;

    localparam int OSC_OFF_BIT   = 7;
    localparam int HR_MODE12_BIT = 6;
    localparam int HR_PM_BIT     = 5;

    function automatic logic [7:0] bcd_inc(input logic [7:0] x);
        if (x[3:0] == 4'd9) return {x[7:4] + 4'd1, 4'd0};
        return {x[7:4], x[3:0] + 4'd1};
    endfunction

    function automatic step_t bcd_step(input logic [7:0] x, input logic [7:0] last,
                                       input logic [7:0] first);
        step_t r;
        if (x == last) begin
            r.carry = 1'b1;
            r.val   = first;
        end else begin
            r.carry = 1'b0;
            r.val   = bcd_inc(x);
        end
        return r;
    endfunction

    function automatic step_t hour_next(input logic [7:0] h);
        step_t      r;
        logic       pm;
        logic [7:0] v;
        if (h[HR_MODE12_BIT]) begin
            pm = h[HR_PM_BIT];
            v  = {3'b000, h[4:0]};
            r.carry = 1'b0;
            if (v == 8'h11) begin
                r.val   = {2'b01, ~pm, 5'h12};
                r.carry = pm;
            end else if (v == 8'h12) begin
                r.val = {2'b01, pm, 5'h01};
            end else begin
                v     = bcd_inc(v);
                r.val = {2'b01, pm, v[4:0]};
            end
        end else begin
            r = bcd_step(h, 8'h23, 8'h00);
        end
        return r;
    endfunction

    function automatic logic leap_year(input logic [7:0] y);
        logic [7:0] b;
        b = ({4'd0, y[7:4]} * 8'd10) + {4'd0, y[3:0]};
        return (b[1:0] == 2'b00);
    endfunction

    function automatic logic [7:0] month_days(input logic [7:0] m, input logic [7:0] y);
        case (m)
            8'h02:                      return leap_year(y) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/cal_prescaler.sv
module cal_prescaler #(
    parameter int PRESCALE_DIV = 32768
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic frac_tick,
    input  logic clr,
    output logic sec_step
);
    localparam int CNT_W = (PRESCALE_DIV > 1) ? $clog2(PRESCALE_DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PRESCALE_DIV - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             at_last;

    assign at_last  = (cnt_q == LAST);
    assign sec_step = run & frac_tick & at_last & ~clr;

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt_q <= '0;
        else if (run && frac_tick)
            cnt_q <= at_last ? '0 : cnt_q + CNT_W'(1);
    end

    // R3: with a divider above one, two seconds never come back to back
    p_single_step_r3: assert property (@(posedge clk) disable iff (rst)
        (PRESCALE_DIV > 1) && sec_step |=> !sec_step);

endmodule

// File: rtl/cal_hms.sv
module cal_hms
    import cal_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sec_step,
    input  logic       wr_en,
    input  reg_addr_e  wr_sel,
    input  logic [7:0] wr_data,
    output logic [7:0] sec_q,
    output logic [7:0] min_q,
    output logic [7:0] hour_q,
    output logic       day_step
);
    step_t sec_nx, min_nx, hr_nx;
    logic  min_en, hr_en;
    logic  wr_sec, wr_min, wr_hour;

    assign wr_sec  = wr_en && (wr_sel == A_SEC);
    assign wr_min  = wr_en && (wr_sel == A_MIN);
    assign wr_hour = wr_en && (wr_sel == A_HOUR);

    always_comb begin
        sec_nx   = bcd_step(sec_q, 8'h59, 8'h00);
        min_nx   = bcd_step(min_q, 8'h59, 8'h00);
        hr_nx    = hour_next(hour_q);
        min_en   = sec_step & sec_nx.carry;
        hr_en    = min_en & min_nx.carry;
        day_step = hr_en & hr_nx.carry;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sec_q  <= 8'h00;
            min_q  <= 8'h00;
            hour_q <= 8'h00;
        end else begin
            if (wr_sec)        sec_q  <= wr_data;
            else if (sec_step) sec_q  <= sec_nx.val;
            if (wr_min)        min_q  <= wr_data;
            else if (min_en)   min_q  <= min_nx.val;
            if (wr_hour)       hour_q <= wr_data;
            else if (hr_en)    hour_q <= hr_nx.val;
        end
    end

    p_sec_wrap_r4: assert property (@(posedge clk) disable iff (rst)
        sec_step && sec_q == 8'h59 && !wr_en |=> sec_q == 8'h00);

    p_mode12_kept_r6: assert property (@(posedge clk) disable iff (rst)
        hr_en && hour_q[HR_MODE12_BIT] && !wr_hour |=> hour_q[HR_MODE12_BIT]);

    p_noon_pm_r6: assert property (@(posedge clk) disable iff (rst)
        hr_en && hour_q == 8'h51 && !wr_hour |=> hour_q == 8'h72);

    p_midnight_r5: assert property (@(posedge clk) disable iff (rst)
        hr_en && hour_q == 8'h23 && !wr_hour |=> hour_q == 8'h00);

endmodule

// File: rtl/cal_date.sv
module cal_date
    import cal_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       day_step,
    input  logic       wr_en,
    input  reg_addr_e  wr_sel,
    input  logic [7:0] wr_data,
    output logic [7:0] wday_q,
    output logic [7:0] date_q,
    output logic [7:0] month_q,
    output logic [7:0] year_q
);
    step_t date_nx, month_nx, year_nx;
    logic  month_en, year_en;

    always_comb begin
        date_nx  = bcd_step(date_q, month_days(month_q, year_q), 8'h01);
        month_nx = bcd_step(month_q, 8'h12, 8'h01);
        year_nx  = bcd_step(year_q, 8'h99, 8'h00);
        month_en = day_step & date_nx.carry;
        year_en  = month_en & month_nx.carry;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wday_q  <= 8'h01;
            date_q  <= 8'h01;
            month_q <= 8'h01;
            year_q  <= 8'h00;
        end else begin
            if (wr_en && wr_sel == A_WDAY)       wday_q  <= wr_data;
            else if (day_step)                   wday_q  <= (wday_q == 8'h07) ? 8'h01 : wday_q + 8'h01;
            if (wr_en && wr_sel == A_DATE)       date_q  <= wr_data;
            else if (day_step)                   date_q  <= date_nx.val;
            if (wr_en && wr_sel == A_MONTH)      month_q <= wr_data;
            else if (month_en)                   month_q <= month_nx.val;
            if (wr_en && wr_sel == A_YEAR)       year_q  <= wr_data;
            else if (year_en)                    year_q  <= year_nx.val;
        end
    end

    p_wday_wrap_r7: assert property (@(posedge clk) disable iff (rst)
        day_step && wday_q == 8'h07 && !wr_en |=> wday_q == 8'h01);

    p_leap_feb_r8: assert property (@(posedge clk) disable iff (rst)
        day_step && month_q == 8'h02 && date_q == 8'h28 && year_q == 8'h24 && !wr_en
        |=> date_q == 8'h29);

    p_year_roll_r9: assert property (@(posedge clk) disable iff (rst)
        day_step && month_q == 8'h12 && date_q == 8'h31 && !wr_en
        |=> month_q == 8'h01 && year_q != $past(year_q));

endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
    import cal_pkg::*;
#(
    parameter int PRESCALE_DIV = 32768
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       frac_tick,
    input  logic       wr_en,
    input  logic [2:0] wr_addr,
    input  logic [7:0] wr_data,
    output logic [7:0] sec_o,
    output logic [7:0] min_o,
    output logic [7:0] hour_o,
    output logic [7:0] wday_o,
    output logic [7:0] date_o,
    output logic [7:0] month_o,
    output logic [7:0] year_o,
    output logic       sec_tick
);
    reg_addr_e wr_sel;
    logic      osc_off_q;
    logic      sec_step, day_step, sec_wr;

    assign wr_sel = reg_addr_e'(wr_addr);
    assign sec_wr = wr_en && (wr_sel == A_SEC);

    always_ff @(posedge clk) begin
        if (rst) begin
            osc_off_q <= 1'b1;
            sec_tick  <= 1'b0;
        end else begin
            if (wr_en && wr_sel == A_CTRL) osc_off_q <= wr_data[OSC_OFF_BIT];
            sec_tick <= sec_step;
        end
    end

    cal_prescaler #(.PRESCALE_DIV(PRESCALE_DIV)) u_pre (
        .clk(clk), .rst(rst), .run(~osc_off_q), .frac_tick(frac_tick),
        .clr(sec_wr), .sec_step(sec_step)
    );

    cal_hms u_hms (
        .clk(clk), .rst(rst), .sec_step(sec_step), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .sec_q(sec_o), .min_q(min_o), .hour_q(hour_o),
        .day_step(day_step)
    );

    cal_date u_date (
        .clk(clk), .rst(rst), .day_step(day_step), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .wday_q(wday_o), .date_q(date_o), .month_q(month_o),
        .year_q(year_o)
    );

    p_frozen_r2: assert property (@(posedge clk) disable iff (rst)
        osc_off_q && !wr_en |=> $stable({sec_o, min_o, hour_o, wday_o, date_o, month_o, year_o}));

    p_tick_running_r3: assert property (@(posedge clk) disable iff (rst)
        sec_tick |-> $past(!osc_off_q));

endmodule

// File: tb/bcd_rtc_core_tb.sv
module bcd_rtc_core_tb;
    localparam int DIV = 3;

    logic       clk = 1'b0;
    logic       rst, frac_tick, wr_en;
    logic [2:0] wr_addr;
    logic [7:0] wr_data;
    logic [7:0] sec_o, min_o, hour_o, wday_o, date_o, month_o, year_o;
    logic       sec_tick;

    int    total = 0, bad = 0;
    bit    done = 0, started = 0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    bcd_rtc_core #(.PRESCALE_DIV(DIV)) u_dut (
        .clk(clk), .rst(rst), .frac_tick(frac_tick), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .wday_o(wday_o),
        .date_o(date_o), .month_o(month_o), .year_o(year_o), .sec_tick(sec_tick)
    );

    // behavioural reference
    int m_sec, m_min, m_h24, m_wday, m_date, m_mon, m_year, m_pre;
    bit m_m12, m_off, m_tick;

    function automatic int from_bcd(logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction
    function automatic logic [7:0] to_bcd(int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction
    function automatic logic [7:0] enc_hour(int h24, bit m12);
        int h12;
        if (!m12) return to_bcd(h24);
        h12 = (h24 % 12 == 0) ? 12 : h24 % 12;
        return 8'h40 | (h24 >= 12 ? 8'h20 : 8'h00) | to_bcd(h12);
    endfunction
    function automatic int dim(int mo, int yr);
        if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    always @(posedge clk) begin
        bit step;
        if (rst) begin
            m_sec = 0; m_min = 0; m_h24 = 0; m_m12 = 0; m_wday = 1; m_date = 1;
            m_mon = 1; m_year = 0; m_pre = 0; m_off = 1; m_tick = 0;
            started = 1;
        end else begin
            step = 0;
            if (!m_off && frac_tick) begin
                if (m_pre == DIV - 1) begin m_pre = 0; step = 1; end
                else m_pre++;
            end
            if (wr_en && wr_addr == 3'd0) begin m_pre = 0; step = 0; end
            if (step) begin
                m_sec++;
                if (m_sec == 60) begin
                    m_sec = 0; m_min++;
                    if (m_min == 60) begin
                        m_min = 0; m_h24++;
                        if (m_h24 == 24) begin
                            m_h24 = 0;
                            m_wday = m_wday % 7 + 1;
                            m_date++;
                            if (m_date > dim(m_mon, m_year)) begin
                                m_date = 1; m_mon++;
                                if (m_mon == 13) begin m_mon = 1; m_year = (m_year + 1) % 100; end
                            end
                        end
                    end
                end
            end
            m_tick = step;
            if (wr_en) begin
                case (wr_addr)
                    3'd0: m_sec = from_bcd(wr_data);
                    3'd1: m_min = from_bcd(wr_data);
                    3'd2: begin
                        m_m12 = wr_data[6];
                        if (wr_data[6])
                            m_h24 = from_bcd({3'b000, wr_data[4:0]}) % 12 + (wr_data[5] ? 12 : 0);
                        else
                            m_h24 = from_bcd(wr_data);
                    end
                    3'd3: m_wday = int'(wr_data);
                    3'd4: m_date = from_bcd(wr_data);
                    3'd5: m_mon = from_bcd(wr_data);
                    3'd6: m_year = from_bcd(wr_data);
                    default: m_off = wr_data[7];
                endcase
            end
        end
    end

    // every-cycle comparison against the model
    always @(negedge clk) begin
        logic [56:0] act, exp;
        if (started && !rst && !done) begin
            act = {sec_o, min_o, hour_o, wday_o, date_o, month_o, year_o, sec_tick};
            exp = {to_bcd(m_sec), to_bcd(m_min), enc_hour(m_h24, m_m12), 8'(m_wday),
                   to_bcd(m_date), to_bcd(m_mon), to_bcd(m_year), m_tick};
            total++;
            if (act !== exp) begin
                bad++;
                $display("FAIL %s model compare actual=%h expected=%h", cur_req, act, exp);
            end
        end
    end

    task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr_reg(logic [2:0] a, logic [7:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic frac_pulses(int n);
        for (int i = 0; i < n; i++) begin
            frac_tick = 1;
            @(negedge clk);
        end
        frac_tick = 0;
    endtask

    task automatic set_time(logic [7:0] s, logic [7:0] mi, logic [7:0] h, logic [7:0] wd,
                            logic [7:0] d, logic [7:0] mo, logic [7:0] y);
        wr_reg(3'd0, s); wr_reg(3'd1, mi); wr_reg(3'd2, h); wr_reg(3'd3, wd);
        wr_reg(3'd4, d); wr_reg(3'd5, mo); wr_reg(3'd6, y);
    endtask

    task automatic summary;
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1; total++; bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        rst = 1; frac_tick = 0; wr_en = 0; wr_addr = 0; wr_data = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        chk("R1", "sec", sec_o, 8'h00);
        chk("R1", "hour", hour_o, 8'h00);
        chk("R1", "wday", wday_o, 8'h01);
        chk("R1", "date", date_o, 8'h01);
        chk("R1", "month", month_o, 8'h01);
        chk("R1", "year", year_o, 8'h00);
        chk("R1", "tick", {7'd0, sec_tick}, 8'h00);

        // R2 stopped after reset
        cur_req = "R2";
        frac_pulses(3 * DIV);
        chk("R2", "sec while stopped", sec_o, 8'h00);

        // R3 start and count one second
        wr_reg(3'd7, 8'h00);
        cur_req = "R3";
        frac_pulses(DIV - 1);
        chk("R3", "sec before period", sec_o, 8'h00);
        frac_pulses(1);
        chk("R3", "sec after period", sec_o, 8'h01);
        chk("R3", "tick high", {7'd0, sec_tick}, 8'h01);
        @(negedge clk);
        chk("R3", "tick one cycle", {7'd0, sec_tick}, 8'h00);

        // R4 R5 R7 R8: midnight Feb 28 in a non-leap year
        cur_req = "R5";
        set_time(8'h58, 8'h59, 8'h23, 8'h07, 8'h28, 8'h02, 8'h23);
        chk("R10", "hour readback", hour_o, 8'h23);
        frac_pulses(DIV);
        chk("R4", "sec 59", sec_o, 8'h59);
        frac_pulses(DIV);
        chk("R4", "min wrap", min_o, 8'h00);
        chk("R5", "hour wrap", hour_o, 8'h00);
        chk("R7", "wday wrap", wday_o, 8'h01);
        chk("R8", "feb28 nonleap date", date_o, 8'h01);
        chk("R8", "feb28 nonleap month", month_o, 8'h03);

        // R8 leap year
        cur_req = "R8";
        set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h24);
        frac_pulses(DIV);
        chk("R8", "leap feb29", date_o, 8'h29);
        set_time(8'h59, 8'h59, 8'h23, 8'h04, 8'h29, 8'h02, 8'h24);
        frac_pulses(DIV);
        chk("R8", "leap mar1 date", date_o, 8'h01);
        chk("R8", "leap mar1 month", month_o, 8'h03);
        set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h04, 8'h31);
        frac_pulses(DIV);
        chk("R8", "apr30 month", month_o, 8'h05);
        set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h01, 8'h31);
        frac_pulses(DIV);
        chk("R8", "jan30 stays jan", date_o, 8'h31);

        // R9 year end
        cur_req = "R9";
        set_time(8'h59, 8'h59, 8'h23, 8'h05, 8'h31, 8'h12, 8'h99);
        frac_pulses(DIV);
        chk("R9", "month wrap", month_o, 8'h01);
        chk("R9", "year wrap", year_o, 8'h00);
        chk("R9", "date", date_o, 8'h01);

        // R6 12-hour mode
        cur_req = "R6";
        set_time(8'h59, 8'h59, 8'h51, 8'h02, 8'h10, 8'h06, 8'h30);
        frac_pulses(DIV);
        chk("R6", "11am to 12pm", hour_o, 8'h72);
        set_time(8'h59, 8'h59, 8'h72, 8'h02, 8'h10, 8'h06, 8'h30);
        frac_pulses(DIV);
        chk("R6", "12pm to 1pm", hour_o, 8'h61);
        set_time(8'h59, 8'h59, 8'h52, 8'h02, 8'h10, 8'h06, 8'h30);
        frac_pulses(DIV);
        chk("R6", "12am to 1am", hour_o, 8'h41);
        set_time(8'h59, 8'h59, 8'h71, 8'h02, 8'h10, 8'h06, 8'h30);
        frac_pulses(DIV);
        chk("R6", "11pm to 12am", hour_o, 8'h52);
        chk("R6", "date advance", date_o, 8'h11);

        // R11 seconds write clears prescaler
        cur_req = "R11";
        frac_pulses(2);
        wr_reg(3'd0, 8'h10);
        frac_pulses(DIV - 1);
        chk("R11", "no early second", sec_o, 8'h10);
        frac_pulses(1);
        chk("R11", "full period", sec_o, 8'h11);

        // R10 write wins over carry of same field
        cur_req = "R10";
        wr_reg(3'd0, 8'h59);
        wr_reg(3'd1, 8'h05);
        frac_pulses(DIV - 1);
        frac_tick = 1; wr_en = 1; wr_addr = 3'd1; wr_data = 8'h30;
        @(negedge clk);
        frac_tick = 0; wr_en = 0;
        chk("R10", "sec still steps", sec_o, 8'h00);
        chk("R10", "min write wins", min_o, 8'h30);

        // R2 stop mid-run, restart with other control bits set
        cur_req = "R2";
        wr_reg(3'd7, 8'h80);
        frac_pulses(4 * DIV);
        chk("R2", "stopped again", sec_o, 8'h00);
        wr_reg(3'd7, 8'h7F);
        frac_pulses(DIV);
        chk("R2", "restart", sec_o, 8'h01);

        @(negedge clk);
        done = 1;
        summary();
        $finish;
    end
endmodule